// File: doc/BRIEF.md
# Grouped Burst Sampling Sequencer

This block paces an analog-to-digital converter in a multichannel acquisition front end. It emits a one-cycle convert strobe together with the channel number that the strobe belongs to, and a busy flag while a run is in progress. A single-cycle start strobe launches a run. The run goes on until the enable input is cleared.

In continuous mode, strobes follow each other at a fixed pace, set by a divisor of the system clock. The channel number steps upward through a contiguous range and wraps back to its first channel. In grouped mode, the block sweeps the channel range a programmed number of times at that same pace, which makes one burst. A conversion allowance follows the burst, and then a pause before the next group. The pause is either a programmed tick count or the wait for a rising edge of an external group clock. That external clock passes through a synchronizer first. Rising edges that arrive while a burst is still converting are dropped.

Top module: `sample_sequencer`

## Requirements
- R1: While reset is held, and directly after it is released, busy and convert are low.
- R2: Convert is high for exactly one cycle. With a start accepted at a clock edge, the first convert is visible in the cycle that follows that edge. In continuous mode, adjacent converts are exactly DIV cycles apart with no pause, where DIV is the pace divisor. A divisor below 2 acts as 2.
- R3: The channel output is valid while convert is high. It rises by one from first_ch to last_ch and then wraps to first_ch, so each sweep holds last_ch − first_ch + 1 converts.
- R4: In grouped mode, one group consists of LOOPS complete sweeps at DIV spacing. A loops value of 0 acts as 1.
- R5: In grouped mode with the internal pause, the first converts of successive groups lie exactly DIV·N·LOOPS + CONV + GAP cycles apart, where N is the channel count. A gap value of 0 acts as 1. No convert occurs during the pause.
- R6: In grouped mode with ext_sel high, the block waits after start with busy high and issues no convert. Each rising edge of ext_clk seen while waiting starts exactly one group. The group's first convert is visible in the cycle after the third clock edge that follows the change on ext_clk.
- R7: A rising edge of ext_clk that arrives during a burst, or during its conversion allowance, starts no group.
- R8: Edges on ext_clk before the start strobe cause no convert and do not set busy.
- R9: While enable is low, a start is ignored. Clearing enable makes busy and convert low after the next clock edge.
- R10: Busy rises in the cycle after an accepted start. A start strobe received while busy has no effect on the convert timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low forces idle |
| start | input | 1 | Single-cycle launch strobe |
| grouped_mode | input | 1 | 1 = grouped bursts, 0 = continuous |
| ext_sel | input | 1 | In grouped mode, pace groups by ext_clk edges |
| pace_div | input | DIV_W | Convert spacing in clock cycles |
| first_ch | input | CH_W | Lowest channel of the sweep |
| last_ch | input | CH_W | Highest channel of the sweep |
| loops | input | LOOP_W | Sweeps per group |
| conv_ticks | input | CONV_W | Conversion allowance after a burst, in cycles |
| gap_ticks | input | GAP_W | Internal pause between groups, in cycles |
| ext_clk | input | 1 | Asynchronous external group clock |
| convert | output | 1 | Convert strobe |
| channel | output | CH_W | Channel of the current convert |
| busy | output | 1 | Run in progress |

## Verification
The hardest case to reach is an external rising edge that lands inside a burst. The bench must place that edge after the synchronizer delay and before the conversion allowance ends. It does this by timing the ext_clk toggles against a cycle counter that starts at the group's first convert. It then counts the strobes, so that a wrongly accepted edge shows up as one group too many. Random internal-pause runs cover the case where the last sweep, the allowance and the pause meet, with small values of loops, gap and divisor, including the zero values that act as one.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RUN,
    S_TAIL,
    S_GAP,
    S_ARM
  } seq_state_e;
endpackage

// File: rtl/seq_downcnt.sv
module seq_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic [W-1:0] count,
  output logic         zero
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (load)                  count <= load_val;
    else if (tick && count != '0)   count <= count - ONE;
  end

  assign zero = (count == '0);
endmodule

// File: rtl/seq_edge_sync.sv
module seq_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign rise = sync_q & ~hist_q;
endmodule

// File: rtl/seq_sweep.sv
module seq_sweep #(
  parameter int CH_W   = 5,
  parameter int LOOP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  input  logic [CH_W-1:0]   first_ch,
  input  logic [CH_W-1:0]   last_ch,
  input  logic [LOOP_W-1:0] loops,
  output logic [CH_W-1:0]   ch,
  output logic              grp_last
);
  localparam logic [LOOP_W-1:0] L_ONE = LOOP_W'(1);
  localparam logic [CH_W-1:0]   C_ONE = CH_W'(1);

  logic [LOOP_W-1:0] loop_idx;
  logic [LOOP_W-1:0] loops_eff;
  logic              at_last_ch;

  assign loops_eff  = (loops == '0) ? L_ONE : loops;
  assign at_last_ch = (ch == last_ch);
  assign grp_last   = at_last_ch && (loop_idx == loops_eff - L_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch       <= '0;
      loop_idx <= '0;
    end else if (restart) begin
      ch       <= first_ch;
      loop_idx <= '0;
    end else if (step) begin
      if (at_last_ch) begin
        ch       <= first_ch;
        loop_idx <= grp_last ? '0 : loop_idx + L_ONE;
      end else begin
        ch <= ch + C_ONE;
      end
    end
  end
endmodule

// File: rtl/sample_sequencer.sv
module sample_sequencer #(
  parameter int DIV_W  = 32,
  parameter int CH_W   = 5,
  parameter int LOOP_W = 8,
  parameter int GAP_W  = 24,
  parameter int CONV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic              grouped_mode,
  input  logic              ext_sel,
  input  logic [DIV_W-1:0]  pace_div,
  input  logic [CH_W-1:0]   first_ch,
  input  logic [CH_W-1:0]   last_ch,
  input  logic [LOOP_W-1:0] loops,
  input  logic [CONV_W-1:0] conv_ticks,
  input  logic [GAP_W-1:0]  gap_ticks,
  input  logic              ext_clk,
  output logic              convert,
  output logic [CH_W-1:0]   channel,
  output logic              busy
);
  import seq_pkg::*;

  localparam int TAIL_W = ((DIV_W > CONV_W) ? DIV_W : CONV_W) + 1;

  function automatic logic [DIV_W-1:0] f_div_eff(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(2)) ? DIV_W'(2) : d;
  endfunction

  function automatic logic [TAIL_W-1:0] f_tail_load(input logic [DIV_W-1:0] d,
                                                    input logic [CONV_W-1:0] c);
    return TAIL_W'(f_div_eff(d)) + TAIL_W'(c) - TAIL_W'(2);
  endfunction

  function automatic logic [GAP_W-1:0] f_gap_load(input logic [GAP_W-1:0] g);
    return (g == '0) ? '0 : g - GAP_W'(1);
  endfunction

  seq_state_e state, nxt;

  logic enter_run, tail_ld, gap_ld;
  logic pace_zero, tail_zero, gap_zero;
  logic conv_fire, grp_last, ext_rise;
  logic in_gap, armed;
  logic [DIV_W-1:0]  pace_cnt;
  logic [TAIL_W-1:0] tail_cnt;
  logic [GAP_W-1:0]  gap_cnt;

  assign conv_fire = (state == S_RUN) && pace_zero;
  assign in_gap    = (state == S_GAP);
  assign armed     = (state == S_ARM);

  seq_edge_sync u_ext_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise(ext_rise)
  );

  always_comb begin
    nxt       = state;
    enter_run = 1'b0;
    tail_ld   = 1'b0;
    gap_ld    = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        if (grouped_mode && ext_sel) nxt = S_ARM;
        else begin nxt = S_RUN; enter_run = 1'b1; end
      end
      S_RUN: if (conv_fire && grouped_mode && grp_last) begin
        nxt = S_TAIL; tail_ld = 1'b1;
      end
      S_TAIL: if (tail_zero) begin
        if (ext_sel) nxt = S_ARM;
        else begin nxt = S_GAP; gap_ld = 1'b1; end
      end
      S_GAP: if (gap_zero) begin nxt = S_RUN; enter_run = 1'b1; end
      S_ARM: if (ext_rise) begin nxt = S_RUN; enter_run = 1'b1; end
      default: nxt = S_IDLE;
    endcase
    if (!enable) begin
      nxt       = S_IDLE;
      enter_run = 1'b0;
      tail_ld   = 1'b0;
      gap_ld    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  seq_downcnt #(.W(DIV_W)) u_pace (
    .clk(clk), .rst_n(rst_n),
    .load(enter_run | conv_fire),
    .load_val(enter_run ? '0 : f_div_eff(pace_div) - DIV_W'(1)),
    .tick(state == S_RUN), .count(pace_cnt), .zero(pace_zero)
  );

  seq_downcnt #(.W(TAIL_W)) u_tail (
    .clk(clk), .rst_n(rst_n), .load(tail_ld),
    .load_val(f_tail_load(pace_div, conv_ticks)),
    .tick(state == S_TAIL), .count(tail_cnt), .zero(tail_zero)
  );

  seq_downcnt #(.W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_ld),
    .load_val(f_gap_load(gap_ticks)),
    .tick(in_gap), .count(gap_cnt), .zero(gap_zero)
  );

  seq_sweep #(.CH_W(CH_W), .LOOP_W(LOOP_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .restart(enter_run), .step(conv_fire),
    .first_ch(first_ch), .last_ch(last_ch), .loops(loops),
    .ch(channel), .grp_last(grp_last)
  );

  assign convert = conv_fire;
  assign busy    = (state != S_IDLE);
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int DIV_W = 32,
  parameter int CH_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             start,
  input logic             busy,
  input logic             convert,
  input logic [CH_W-1:0]  channel,
  input logic [CH_W-1:0]  first_ch,
  input logic [CH_W-1:0]  last_ch,
  input logic [DIV_W-1:0] pace_div,
  input logic             in_gap,
  input logic             armed
);
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (convert && pace_div > DIV_W'(1)) |=> !convert);

  p_channel_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    convert |-> (channel >= first_ch && channel <= last_ch));

  p_gap_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> (!convert && busy));

  p_armed_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !convert);

  p_disable_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !convert));

  p_convert_in_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    convert |-> busy);

  p_start_sets_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && enable) |=> busy);
endmodule

bind sample_sequencer seq_checker #(.DIV_W(DIV_W), .CH_W(CH_W)) u_seq_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .busy(busy),
  .convert(convert), .channel(channel), .first_ch(first_ch), .last_ch(last_ch),
  .pace_div(pace_div), .in_gap(in_gap), .armed(armed)
);

// File: tb/test_sample_sequencer.sv
module test_sample_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, start = 1'b0, grouped_mode = 1'b0, ext_sel = 1'b0;
  logic [31:0] pace_div = 32'd2;
  logic [4:0]  first_ch = '0, last_ch = '0;
  logic [7:0]  loops = 8'd1;
  logic [15:0] conv_ticks = '0;
  logic [23:0] gap_ticks = 24'd1;
  logic        ext_clk = 1'b0;
  logic        convert, busy;
  logic [4:0]  channel;

  int     checks = 0, errors = 0;
  longint cyc = 0;
  longint ev_t [256];
  int     ev_ch [256];
  int     n_ev = 0;

  sample_sequencer i_sample_sequencer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
    .grouped_mode(grouped_mode), .ext_sel(ext_sel), .pace_div(pace_div),
    .first_ch(first_ch), .last_ch(last_ch), .loops(loops),
    .conv_ticks(conv_ticks), .gap_ticks(gap_ticks), .ext_clk(ext_clk),
    .convert(convert), .channel(channel), .busy(busy)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (convert && n_ev < 256) begin
    ev_t[n_ev]  = cyc;
    ev_ch[n_ev] = int'(channel);
    n_ev++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_time(input int k, input bit grp, input int n,
                                      input int lp, input int dv, input int cv, input int gp);
    int per_grp, g, j;
    if (!grp) return longint'(k) * dv;
    per_grp = n * ((lp == 0) ? 1 : lp);
    g = k / per_grp;
    j = k % per_grp;
    return longint'(g) * (per_grp * dv + cv + ((gp == 0) ? 1 : gp)) + longint'(j) * dv;
  endfunction

  task automatic run_int(input bit grp, input int fc, input int n, input int lp,
                         input int dv, input int cv, input int gp, input int reps,
                         input bit poke);
    longint s, last_t;
    int nev;
    string tag;
    tag = grp ? "R5" : "R2";
    grouped_mode = grp; ext_sel = 1'b0;
    first_ch = 5'(fc); last_ch = 5'(fc + n - 1);
    loops = 8'(lp); pace_div = 32'(dv); conv_ticks = 16'(cv); gap_ticks = 24'(gp);
    nev = grp ? n * ((lp == 0) ? 1 : lp) * reps : n * reps + 1;
    @(negedge clk); n_ev = 0; start = 1'b1; s = cyc + 1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R10 busy after start", longint'(busy), 1);
    last_t = exp_time(nev - 1, grp, n, lp, dv, cv, gp);
    while (cyc < s + last_t) begin
      @(negedge clk);
      start = poke && (cyc == s + 1);
    end
    start = 1'b0;
    enable = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && convert === 1'b0, "R9 idle after enable cleared", longint'(busy), 0);
    chk(n_ev == nev, grp ? "R4 convert count" : "R2 convert count", n_ev, nev);
    for (int k = 0; k < nev && k < n_ev; k++) begin
      chk(ev_t[k] - s == exp_time(k, grp, n, lp, dv, cv, gp), tag,
          ev_t[k] - s, exp_time(k, grp, n, lp, dv, cv, gp));
      chk(ev_ch[k] == fc + (k % n), "R3 channel", ev_ch[k], fc + (k % n));
    end
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_ext();
    longint t1, t2;
    grouped_mode = 1'b1; ext_sel = 1'b1;
    first_ch = 5'd2; last_ch = 5'd4; loops = 8'd2;
    pace_div = 32'd3; conv_ticks = 16'd4; gap_ticks = 24'd9;
    n_ev = 0;
    for (int i = 0; i < 4; i++) begin
      repeat (3) @(negedge clk); ext_clk = 1'b1;
      repeat (3) @(negedge clk); ext_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
    chk(n_ev == 0 && busy === 1'b0, "R8 edges before start", n_ev, 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    chk(n_ev == 0 && busy === 1'b1, "R6 waiting for edge", n_ev, 0);
    ext_clk = 1'b1; t1 = cyc;
    repeat (6) @(negedge clk); ext_clk = 1'b0;
    repeat (3) @(negedge clk); ext_clk = 1'b1;
    repeat (36) @(negedge clk);
    chk(n_ev == 6, "R7 edge inside burst dropped", n_ev, 6);
    chk(n_ev > 0 && ev_t[0] - t1 == 3, "R6 first convert latency", ev_t[0] - t1, 3);
    chk(busy === 1'b1, "R6 busy while waiting", longint'(busy), 1);
    ext_clk = 1'b0;
    repeat (3) @(negedge clk); ext_clk = 1'b1; t2 = cyc;
    repeat (30) @(negedge clk);
    chk(n_ev == 12, "R6 one group per edge", n_ev, 12);
    chk(n_ev > 6 && ev_t[6] - t2 == 3, "R6 second group latency", ev_t[6] - t2, 3);
    for (int k = 0; k < n_ev && k < 12; k++) begin
      chk(ev_ch[k] == 2 + (k % 3), "R4 channel order", ev_ch[k], 2 + (k % 3));
      if (k % 6 != 0)
        chk(ev_t[k] - ev_t[k-1] == 3, "R4 spacing", ev_t[k] - ev_t[k-1], 3);
    end
    enable = 1'b0; ext_clk = 1'b0; @(negedge clk);
    chk(busy === 1'b0, "R9 idle after enable cleared", longint'(busy), 0);
    enable = 1'b1; @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, fc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && convert === 1'b0, "R1 in reset", longint'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && convert === 1'b0, "R1 after reset", longint'(busy), 0);

    start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    chk(busy === 1'b0 && n_ev == 0, "R9 start ignored while disabled", longint'(busy), 0);
    enable = 1'b1; @(negedge clk);

    run_int(1'b0, 3, 4, 1, 4, 0, 1, 3, 1'b1);
    run_int(1'b0, 7, 1, 1, 2, 0, 1, 5, 1'b0);
    run_int(1'b1, 0, 2, 2, 5, 3, 6, 3, 1'b0);
    run_int(1'b1, 10, 3, 0, 2, 0, 0, 3, 1'b0);
    for (int it = 0; it < 8; it++) begin
      n  = 1 + int'($urandom % 6);
      fc = int'($urandom % 20);
      run_int(1'b1, fc, n, int'($urandom % 4), 2 + int'($urandom % 5),
              int'($urandom % 6), int'($urandom % 9), 3, 1'b0);
    end
    run_int(1'b0, int'($urandom % 16), 1 + int'($urandom % 8), 1,
            2 + int'($urandom % 7), 0, 1, 3, 1'b0);
    run_ext();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule